// File: doc/BRIEF.md
# Standby Mode Controller

This block holds one byte-wide control register on a small CPU write/read port and uses it to move a core out of normal running into one of two low-power states. A sleep request stops only the core clock. A stop request stops both the core clock and the peripheral clock. While the block is stopped it also drives the external pins in one of two ways. Either every pin keeps the level and drive it had, or every pin is released to high impedance, with a pull-up applied on the pins whose pull-up enable is set.

Software enters a low-power state by writing a request bit. A later wake event or interrupt request brings the controller back to run. A request to enter a low-power state is dropped if an interrupt request is already pending in the cycle of the write. Two more write-only bits, software reset and timer mode, store nothing. Each one only produces a one-cycle pulse on its own output. All outputs come from registers.

Top module: `stby_ctrl`

## Requirements
- R1: During and after a synchronous reset the mode is run (mode_o = 2'b00). Both clock enables are 1. The pin outputs, bus_rdata, the pulse outputs and the stored pin policy are all 0.
- R2: A read at address REG_ADDR (default 0) returns a byte on bus_rdata one cycle after bus_rd. Bit 5 of that byte is the stored pin policy and every other bit is 0. This includes the stop bit (7) and the sleep bit (6). A read at any other address, and any cycle without bus_rd, gives 0. A write to bit 5 updates the stored policy.
- R3: A write with bit 7 set, made in run with no pending interrupt, moves the controller to stop (mode_o = 2'b10) with both clock enables 0. A write with bit 6 set moves it to sleep (mode_o = 2'b01) with only cpu_clk_en at 0. Writing 0 to these bits has no effect.
- R4: If a single write sets both bit 7 and bit 6, the controller enters stop.
- R5: A write with bit 7 or bit 6 set is discarded when irq_pending is 1 in the same cycle. The controller stays in run.
- R6: In sleep or stop, a cycle with wake_evt or irq_pending at 1 returns the controller to run at the next clock edge. The clock enables and the pin outputs return to run behaviour at that same edge.
- R7: If the pin policy in effect at the edge that enters stop is 0, pin_drv_o, pin_oe_o and pin_pu_o keep their values for the whole stay in stop. The policy in effect is the bit-5 value being written in that cycle if there is one, and the stored value otherwise.
- R8: If that policy is 1, then in stop pin_oe_o and pin_drv_o are 0 and pin_pu_o follows pin_pu_en_i.
- R9: In run and sleep the pin outputs are registered copies of the inputs: pin_drv_o = pin_out_i, pin_oe_o = pin_oe_i and pin_pu_o = pin_pu_en_i & ~pin_oe_i.
- R10: A write with bit 4 set gives swrst_pulse = 1 for exactly the next cycle. A write with bit 3 set does the same on tmr_pulse. Neither bit changes any stored state.
- R11: Writes to addresses other than REG_ADDR are ignored. Bits 2 to 0 are discarded. A bit 7 or bit 6 write made while in sleep or stop does not change the mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | ADDR_W | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| irq_pending | input | 1 | An interrupt request is pending |
| wake_evt | input | 1 | Wake event |
| pin_out_i | input | NUM_PINS | Pin levels requested by the core |
| pin_oe_i | input | NUM_PINS | Pin output enables requested by the core |
| pin_pu_en_i | input | NUM_PINS | Pull-up enable for each pin |
| mode_o | output | 2 | 00 run, 01 sleep, 10 stop |
| cpu_clk_en | output | 1 | Core clock enable |
| per_clk_en | output | 1 | Peripheral clock enable |
| pin_drv_o | output | NUM_PINS | Pin drive level |
| pin_oe_o | output | NUM_PINS | Pin output enable |
| pin_pu_o | output | NUM_PINS | Pin pull-up on |
| swrst_pulse | output | 1 | One-cycle software reset pulse |
| tmr_pulse | output | 1 | One-cycle timer-mode pulse |

## Verification
The collision that matters is a mode-entry write made in the same cycle that an interrupt request is pending. The write must be dropped, but the bit-5 policy and any pulse bits in that same byte must still take effect. A directed case writes a stop request with irq_pending held high. The random phase raises irq_pending at random with mode writes mixed in. A second overlap is a write that both enters stop and changes the pin policy, which is judged by checking that the newly written policy decides hold or release from the first stopped cycle onward. A bench model built from the requirements predicts every output for every cycle.

// File: rtl/stby_pkg.sv
`timescale 1ns/1ps
package stby_pkg;
  typedef enum logic [1:0] {
    MODE_RUN   = 2'b00,
    MODE_SLEEP = 2'b01,
    MODE_STOP  = 2'b10
  } mode_e;

  localparam int REG_W      = 8;
  localparam int BIT_STOP   = 7;
  localparam int BIT_SLEEP  = 6;
  localparam int BIT_PINREL = 5;
  localparam int BIT_SWRST  = 4;
  localparam int BIT_TMR    = 3;
endpackage

// File: rtl/stby_regs.sv
`timescale 1ns/1ps
module stby_regs
  import stby_pkg::*;
#(
  parameter int ADDR_W   = 4,
  parameter int REG_ADDR = 0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [REG_W-1:0]  bus_wdata,
  output logic [REG_W-1:0]  bus_rdata,
  output logic              req_stop,
  output logic              req_sleep,
  output logic              pinrel_q,
  output logic              pinrel_d,
  output logic              swrst_pulse,
  output logic              tmr_pulse
);
  localparam logic [ADDR_W-1:0] HIT_ADDR = ADDR_W'(REG_ADDR);

  logic             addr_hit;
  logic             wr_hit;
  logic             rd_hit;
  logic [REG_W-1:0] rd_word;
  logic             unused_bits;

  assign addr_hit  = (bus_addr == HIT_ADDR);
  assign wr_hit    = bus_wr && addr_hit;
  assign rd_hit    = bus_rd && addr_hit;
  assign req_stop  = wr_hit && bus_wdata[BIT_STOP];
  assign req_sleep = wr_hit && bus_wdata[BIT_SLEEP];
  assign pinrel_d  = wr_hit ? bus_wdata[BIT_PINREL] : pinrel_q;
  // low bits carry nothing
  assign unused_bits = ^bus_wdata[2:0];

  // only the pin policy is visible on reads
  always_comb begin
    rd_word             = '0;
    rd_word[BIT_PINREL] = pinrel_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pinrel_q    <= 1'b0;
      swrst_pulse <= 1'b0;
      tmr_pulse   <= 1'b0;
      bus_rdata   <= '0;
    end else begin
      pinrel_q    <= pinrel_d;
      swrst_pulse <= wr_hit && bus_wdata[BIT_SWRST];
      tmr_pulse   <= wr_hit && bus_wdata[BIT_TMR];
      bus_rdata   <= rd_hit ? rd_word : '0;
    end
  end

  a_r10_swrst_source: assert property (@(posedge clk) disable iff (rst)
    swrst_pulse |-> $past(wr_hit && bus_wdata[BIT_SWRST]));
  a_r10_tmr_source: assert property (@(posedge clk) disable iff (rst)
    tmr_pulse |-> $past(wr_hit && bus_wdata[BIT_TMR]));
  a_r11_foreign_write: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && !addr_hit) |=> $stable(pinrel_q));
  a_r2_read_policy: assert property (@(posedge clk) disable iff (rst)
    rd_hit |=> (bus_rdata[BIT_PINREL] == $past(pinrel_q)));
endmodule

// File: rtl/stby_fsm.sv
`timescale 1ns/1ps
module stby_fsm
  import stby_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  req_stop,
  input  logic  req_sleep,
  input  logic  irq_pending,
  input  logic  wake_evt,
  output mode_e mode_q,
  output mode_e mode_d,
  output logic  cpu_clk_en,
  output logic  per_clk_en
);
  always_comb begin
    mode_d = mode_q;
    unique case (mode_q)
      MODE_RUN: begin
        if (!irq_pending) begin
          if (req_stop)       mode_d = MODE_STOP;
          else if (req_sleep) mode_d = MODE_SLEEP;
        end
      end
      MODE_SLEEP, MODE_STOP: begin
        if (wake_evt || irq_pending) mode_d = MODE_RUN;
      end
      default: mode_d = MODE_RUN;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q     <= MODE_RUN;
      cpu_clk_en <= 1'b1;
      per_clk_en <= 1'b1;
    end else begin
      mode_q     <= mode_d;
      cpu_clk_en <= (mode_d == MODE_RUN);
      per_clk_en <= (mode_d != MODE_STOP);
    end
  end

  a_r5_irq_blocks_entry: assert property (@(posedge clk) disable iff (rst)
    (mode_q == MODE_RUN && irq_pending) |=> (mode_q == MODE_RUN));
  a_r4_stop_wins: assert property (@(posedge clk) disable iff (rst)
    (mode_q == MODE_RUN && req_stop && req_sleep && !irq_pending) |=> (mode_q == MODE_STOP));
  a_r6_wake_returns: assert property (@(posedge clk) disable iff (rst)
    (mode_q != MODE_RUN && (wake_evt || irq_pending)) |=> (mode_q == MODE_RUN && cpu_clk_en && per_clk_en));
  a_r3_stop_clocks_off: assert property (@(posedge clk) disable iff (rst)
    (mode_q == MODE_STOP) |-> (!cpu_clk_en && !per_clk_en));
  a_r3_sleep_clocks: assert property (@(posedge clk) disable iff (rst)
    (mode_q == MODE_SLEEP) |-> (!cpu_clk_en && per_clk_en));
endmodule

// File: rtl/stby_pins.sv
`timescale 1ns/1ps
module stby_pins
  import stby_pkg::*;
#(
  parameter int NUM_PINS = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  mode_e               mode_q,
  input  mode_e               mode_d,
  input  logic                pinrel_d,
  input  logic [NUM_PINS-1:0] pin_out_i,
  input  logic [NUM_PINS-1:0] pin_oe_i,
  input  logic [NUM_PINS-1:0] pin_pu_en_i,
  output logic [NUM_PINS-1:0] pin_drv_o,
  output logic [NUM_PINS-1:0] pin_oe_o,
  output logic [NUM_PINS-1:0] pin_pu_o
);
  logic entering;
  logic stop_next;
  logic rel_q;
  logic rel_eff;

  assign stop_next = (mode_d == MODE_STOP);
  assign entering  = stop_next && (mode_q != MODE_STOP);
  assign rel_eff   = entering ? pinrel_d : rel_q;

  // policy is frozen at the entry edge
  always_ff @(posedge clk) begin
    if (rst)           rel_q <= 1'b0;
    else if (entering) rel_q <= pinrel_d;
  end

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
    always_ff @(posedge clk) begin
      if (rst) begin
        pin_drv_o[i] <= 1'b0;
        pin_oe_o[i]  <= 1'b0;
        pin_pu_o[i]  <= 1'b0;
      end else if (stop_next) begin
        if (rel_eff) begin
          pin_drv_o[i] <= 1'b0;
          pin_oe_o[i]  <= 1'b0;
          pin_pu_o[i]  <= pin_pu_en_i[i];
        end
      end else begin
        pin_drv_o[i] <= pin_out_i[i];
        pin_oe_o[i]  <= pin_oe_i[i];
        pin_pu_o[i]  <= pin_pu_en_i[i] & ~pin_oe_i[i];
      end
    end
  end

  a_r7_hold_stable: assert property (@(posedge clk) disable iff (rst)
    (mode_q == MODE_STOP && $past(mode_q == MODE_STOP) && !rel_q)
      |-> ($stable(pin_drv_o) && $stable(pin_oe_o) && $stable(pin_pu_o)));
  a_r8_release_undriven: assert property (@(posedge clk) disable iff (rst)
    (mode_q == MODE_STOP && rel_q) |-> (pin_oe_o == '0 && pin_drv_o == '0));
  a_r9_run_copy: assert property (@(posedge clk) disable iff (rst)
    (mode_d != MODE_STOP) |=> (pin_drv_o == $past(pin_out_i) && pin_oe_o == $past(pin_oe_i)));
endmodule

// File: rtl/stby_ctrl.sv
`timescale 1ns/1ps
module stby_ctrl
  import stby_pkg::*;
#(
  parameter int ADDR_W   = 4,
  parameter int REG_ADDR = 0,
  parameter int NUM_PINS = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                bus_wr,
  input  logic                bus_rd,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [7:0]          bus_wdata,
  output logic [7:0]          bus_rdata,
  input  logic                irq_pending,
  input  logic                wake_evt,
  input  logic [NUM_PINS-1:0] pin_out_i,
  input  logic [NUM_PINS-1:0] pin_oe_i,
  input  logic [NUM_PINS-1:0] pin_pu_en_i,
  output logic [1:0]          mode_o,
  output logic                cpu_clk_en,
  output logic                per_clk_en,
  output logic [NUM_PINS-1:0] pin_drv_o,
  output logic [NUM_PINS-1:0] pin_oe_o,
  output logic [NUM_PINS-1:0] pin_pu_o,
  output logic                swrst_pulse,
  output logic                tmr_pulse
);
  logic  req_stop;
  logic  req_sleep;
  logic  pinrel_q;
  logic  pinrel_d;
  mode_e mode_q;
  mode_e mode_d;

  stby_regs #(.ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR)) u_regs (
    .clk        (clk),
    .rst        (rst),
    .bus_wr     (bus_wr),
    .bus_rd     (bus_rd),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .bus_rdata  (bus_rdata),
    .req_stop   (req_stop),
    .req_sleep  (req_sleep),
    .pinrel_q   (pinrel_q),
    .pinrel_d   (pinrel_d),
    .swrst_pulse(swrst_pulse),
    .tmr_pulse  (tmr_pulse)
  );

  stby_fsm u_fsm (
    .clk        (clk),
    .rst        (rst),
    .req_stop   (req_stop),
    .req_sleep  (req_sleep),
    .irq_pending(irq_pending),
    .wake_evt   (wake_evt),
    .mode_q     (mode_q),
    .mode_d     (mode_d),
    .cpu_clk_en (cpu_clk_en),
    .per_clk_en (per_clk_en)
  );

  stby_pins #(.NUM_PINS(NUM_PINS)) u_pins (
    .clk        (clk),
    .rst        (rst),
    .mode_q     (mode_q),
    .mode_d     (mode_d),
    .pinrel_d   (pinrel_d),
    .pin_out_i  (pin_out_i),
    .pin_oe_i   (pin_oe_i),
    .pin_pu_en_i(pin_pu_en_i),
    .pin_drv_o  (pin_drv_o),
    .pin_oe_o   (pin_oe_o),
    .pin_pu_o   (pin_pu_o)
  );

  assign mode_o = mode_q;

  a_r11_no_skip: assert property (@(posedge clk) disable iff (rst)
    (mode_q == MODE_SLEEP) |=> (mode_q != MODE_STOP));
  a_r10_pulse_keeps_mode: assert property (@(posedge clk) disable iff (rst)
    (mode_q == MODE_RUN && !req_stop && !req_sleep) |=> (mode_q == MODE_RUN));
endmodule

// File: tb/sim_stby_ctrl.sv
`timescale 1ns/1ps
module sim_stby_ctrl;
  localparam int AW = 4;
  localparam int NP = 8;

  logic          clk = 1'b0;
  logic          rst;
  logic          bus_wr, bus_rd, irq_pending, wake_evt;
  logic [AW-1:0] bus_addr;
  logic [7:0]    bus_wdata, bus_rdata;
  logic [NP-1:0] pin_out_i, pin_oe_i, pin_pu_en_i;
  logic [1:0]    mode_o;
  logic          cpu_clk_en, per_clk_en, swrst_pulse, tmr_pulse;
  logic [NP-1:0] pin_drv_o, pin_oe_o, pin_pu_o;

  stby_ctrl #(.ADDR_W(AW), .REG_ADDR(0), .NUM_PINS(NP)) u0 (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_pending(irq_pending),
    .wake_evt(wake_evt), .pin_out_i(pin_out_i), .pin_oe_i(pin_oe_i),
    .pin_pu_en_i(pin_pu_en_i), .mode_o(mode_o), .cpu_clk_en(cpu_clk_en),
    .per_clk_en(per_clk_en), .pin_drv_o(pin_drv_o), .pin_oe_o(pin_oe_o),
    .pin_pu_o(pin_pu_o), .swrst_pulse(swrst_pulse), .tmr_pulse(tmr_pulse)
  );

  always #2.5 clk = ~clk;

  int  n_chk = 0;
  int  n_fail = 0;
  bit  done = 1'b0;

  // reference model state
  logic [1:0]    m_mode;
  logic          m_spl, m_rel, m_cpu, m_per, m_sw, m_tm;
  logic [7:0]    m_rdata;
  logic [NP-1:0] m_drv, m_oe, m_pu;

  function automatic logic [1:0] next_mode(logic [1:0] cur, logic hit, logic [7:0] d,
                                           logic irq, logic wk);
    logic [1:0] n;
    n = cur;
    if (cur == 2'b00) begin
      if (hit && !irq && d[7])      n = 2'b10;
      else if (hit && !irq && d[6]) n = 2'b01;
    end else if (wk || irq) begin
      n = 2'b00;
    end
    return n;
  endfunction

  task automatic model_edge();
    logic       hit;
    logic [1:0] nm;
    logic       spl_n, rel_e;
    if (rst) begin
      m_mode = 2'b00; m_spl = 0; m_rel = 0; m_cpu = 1; m_per = 1;
      m_sw = 0; m_tm = 0; m_rdata = 0; m_drv = 0; m_oe = 0; m_pu = 0;
      return;
    end
    hit     = bus_wr && (bus_addr == 0);
    m_rdata = (bus_rd && bus_addr == 0) ? {2'b00, m_spl, 5'b00000} : 8'h00;
    m_sw    = hit && bus_wdata[4];
    m_tm    = hit && bus_wdata[3];
    spl_n   = hit ? bus_wdata[5] : m_spl;
    nm      = next_mode(m_mode, hit, bus_wdata, irq_pending, wake_evt);
    if (nm == 2'b10) begin
      rel_e = (m_mode != 2'b10) ? spl_n : m_rel;
      m_rel = rel_e;
      if (rel_e) begin
        m_drv = '0; m_oe = '0; m_pu = pin_pu_en_i;
      end
    end else begin
      m_drv = pin_out_i; m_oe = pin_oe_i; m_pu = pin_pu_en_i & ~pin_oe_i;
    end
    m_spl  = spl_n;
    m_mode = nm;
    m_cpu  = (nm == 2'b00);
    m_per  = (nm != 2'b10);
  endtask

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    chk("R3/R4/R5/R6 mode", 32'(mode_o), 32'(m_mode));
    chk("R3/R6 cpu_clk_en", 32'(cpu_clk_en), 32'(m_cpu));
    chk("R3/R6 per_clk_en", 32'(per_clk_en), 32'(m_per));
    chk("R2 bus_rdata", 32'(bus_rdata), 32'(m_rdata));
    chk("R10 swrst_pulse", 32'(swrst_pulse), 32'(m_sw));
    chk("R10 tmr_pulse", 32'(tmr_pulse), 32'(m_tm));
    chk("R7/R8/R9 pin_drv_o", 32'(pin_drv_o), 32'(m_drv));
    chk("R7/R8/R9 pin_oe_o", 32'(pin_oe_o), 32'(m_oe));
    chk("R7/R8/R9 pin_pu_o", 32'(pin_pu_o), 32'(m_pu));
  endtask

  task automatic step();
    @(posedge clk);
    model_edge();
    #1;
    compare_all();
  endtask

  task automatic idle();
    bus_wr = 0; bus_rd = 0; bus_addr = 0; bus_wdata = 0; irq_pending = 0; wake_evt = 0;
  endtask

  task automatic wr(logic [AW-1:0] a, logic [7:0] d);
    bus_wr = 1; bus_addr = a; bus_wdata = d;
    step();
    bus_wr = 0; bus_wdata = 0;
  endtask

  task automatic rd_reg(logic [AW-1:0] a);
    bus_rd = 1; bus_addr = a;
    step();
    bus_rd = 0;
  endtask

  initial begin
    #(5ns * 200000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    idle();
    pin_out_i = 8'hA5; pin_oe_i = 8'hF0; pin_pu_en_i = 8'h3C;
    rst = 1;
    repeat (3) step();
    rst = 0;
    // R1 reset state
    chk("R1 mode after reset", 32'(mode_o), 0);
    chk("R1 clocks after reset", {cpu_clk_en, per_clk_en}, 32'b11);
    chk("R1 pulses after reset", {swrst_pulse, tmr_pulse}, 0);
    chk("R1 rdata after reset", 32'(bus_rdata), 0);
    step();

    // R2 read of reset value, then policy write and read back
    rd_reg(0);
    chk("R2 read zero", 32'(bus_rdata), 0);
    wr(0, 8'h20);
    rd_reg(0);
    chk("R2 read policy", 32'(bus_rdata), 32'h20);
    rd_reg(3);
    chk("R2 foreign read", 32'(bus_rdata), 0);

    // R3 sleep entry, R11 stop write ignored in sleep, R6 wake
    wr(0, 8'h40);
    chk("R3 sleep mode", 32'(mode_o), 1);
    chk("R3 sleep clocks", {cpu_clk_en, per_clk_en}, 32'b01);
    wr(0, 8'h80);
    chk("R11 no stop from sleep", 32'(mode_o), 1);
    step();
    wake_evt = 1; step(); wake_evt = 0;
    chk("R6 wake to run", 32'(mode_o), 0);

    // R4 both bits, policy 0 -> hold (R7)
    pin_out_i = 8'h5A; pin_oe_i = 8'h0F; pin_pu_en_i = 8'hFF;
    step();
    wr(0, 8'hC0);
    chk("R4 stop wins", 32'(mode_o), 2);
    chk("R3 stop clocks", {cpu_clk_en, per_clk_en}, 0);
    pin_out_i = 8'h00; pin_oe_i = 8'hFF; pin_pu_en_i = 8'h00;
    step(); step();
    chk("R7 drive held", 32'(pin_drv_o), 32'h5A);
    chk("R7 oe held", 32'(pin_oe_o), 32'h0F);
    irq_pending = 1; step(); irq_pending = 0;
    chk("R6 irq wakes", 32'(mode_o), 0);
    chk("R6 pins restored", 32'(pin_oe_o), 32'hFF);

    // R8 same write sets policy and enters stop
    pin_pu_en_i = 8'h96;
    wr(0, 8'hA0);
    chk("R8 oe released", 32'(pin_oe_o), 0);
    chk("R8 pull-ups", 32'(pin_pu_o), 32'h96);
    wake_evt = 1; step(); wake_evt = 0;

    // R5 entry with pending interrupt dropped, policy still written
    irq_pending = 1;
    wr(0, 8'h80);
    irq_pending = 0;
    chk("R5 entry dropped", 32'(mode_o), 0);
    rd_reg(0);
    chk("R5 policy still written", 32'(bus_rdata), 0);

    // R10 pulses
    wr(0, 8'h18);
    chk("R10 swrst pulse", 32'(swrst_pulse), 1);
    chk("R10 tmr pulse", 32'(tmr_pulse), 1);
    step();
    chk("R10 single cycle", {swrst_pulse, tmr_pulse}, 0);

    // R11 foreign address and low bits
    wr(5, 8'hE7);
    chk("R11 foreign write", 32'(mode_o), 0);
    wr(0, 8'h07);
    rd_reg(0);
    chk("R11 low bits discarded", 32'(bus_rdata), 0);

    // random phase
    for (int k = 0; k < 4000; k++) begin
      bus_wr      = ($urandom_range(0, 99) < 15);
      bus_rd      = ($urandom_range(0, 99) < 30);
      bus_addr    = ($urandom_range(0, 9) < 8) ? '0 : AW'($urandom_range(1, 15));
      bus_wdata   = 8'($urandom);
      irq_pending = ($urandom_range(0, 99) < 5);
      wake_evt    = ($urandom_range(0, 99) < 5);
      pin_out_i   = NP'($urandom);
      pin_oe_i    = NP'($urandom);
      pin_pu_en_i = NP'($urandom);
      step();
    end
    idle();
    step();

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule